// File: doc/BRIEF.md
# JTAG Programming Command Register

This block is a 15-bit test data register that sits behind a JTAG TAP controller. It becomes active when the instruction register holds the programming-command code. It gives a debug host a route to a memory-programming engine. When the TAP passes through Capture-DR, the block loads the result of the command that ran before. Through Shift-DR, that result leaves on TDO while the next command enters from TDI. In Update-DR the new command is copied to a held command bus, together with a one-cycle valid pulse. On entry to Run-Test/Idle the block issues one execute strobe for that command.

The TAP controller supplies its state decodes as level signals. Each decode is valid for one TCK period, and the block acts on the rising edge at the end of that period. The command bus comes from a shadow register, so it stays still while a new command is being shifted. The whole register keeps its contents and leaves TDO undriven while a different instruction is loaded.

Top module: `jtag_pgm_cmd_reg`

## Requirements
- R1: While trst_n is low, cmd_q is 0 and cmd_valid, exec_strobe, tdo and tdo_en are all 0. trst_n asserts asynchronously and is released through a two-stage synchronizer, so the first rising TCK edge that acts on the TAP decodes is the third one after trst_n goes high.
- R2: The register is selected only when the 4-bit ir_code equals 4'h5. With any other code, the capture, shift, update and run-idle decodes have no effect on cmd_q, cmd_valid, exec_strobe or TDO.
- R3: A rising edge in Capture-DR loads result_i into the shift stage. In the Shift-DR cycles that follow, tdo presents bit 0 of that value after the first falling edge, then one higher bit after each later falling edge.
- R4: Each rising edge in selected Shift-DR takes tdi into bit 14 and moves every other bit one place toward bit 0. After 15 shifts, bit k holds the k-th TDI bit sent, counting from 0.
- R5: A rising edge in selected Update-DR copies the shift stage onto cmd_q. At every other time, including during shifting, cmd_q holds its value.
- R6: cmd_valid is high for exactly the one TCK cycle after each selected update edge.
- R7: exec_strobe goes high for one cycle after a rising edge where the register is selected and tap_run_idle is high, but only if the same condition was false at the previous edge. It does not fire again however long the TAP stays in Run-Test/Idle.
- R8: tdo_en is high from a falling edge in selected Shift-DR until the first falling edge outside it. tdo is 0 whenever tdo_en is low.
- R9: While the register is not selected, the shift stage keeps its contents. A later selected Shift-DR without a capture shifts out the last command shifted in.
- R10: When Update-DR leads straight into Run-Test/Idle, cmd_valid is high during the first idle cycle. exec_strobe follows one cycle later, and cmd_q has already held the new command for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Current instruction register contents |
| tap_capture_dr | input | 1 | TAP is in Capture-DR |
| tap_shift_dr | input | 1 | TAP is in Shift-DR |
| tap_update_dr | input | 1 | TAP is in Update-DR |
| tap_run_idle | input | 1 | TAP is in Run-Test/Idle |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| result_i | input | 15 | Result of the previously executed command |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | TDO drive enable |
| cmd_q | output | 15 | Command presented to the programming engine |
| cmd_valid | output | 1 | One-cycle pulse when cmd_q is renewed |
| exec_strobe | output | 1 | One-cycle execute strobe |

## Verification
The update pulse and the entry into Run-Test/Idle can fall in adjacent cycles that share state. When Update-DR goes straight to Run-Test/Idle, cmd_valid is still high during the first idle cycle, and the execute strobe is decided on that cycle's closing edge. The bench builds this path in several scans, including one long idle stay. It judges the path by three things: that the strobe comes exactly once, that cmd_q already carries the new command when the strobe is seen, and that the emulated engine's answer to that command is what the next capture shifts out. A reference model running in parallel checks every output on every clock.

// File: rtl/jpc_pkg.sv
package jpc_pkg;

  // Level decodes of the TAP state for the current TCK period
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic idle;
  } tap_step_t;

endpackage

// File: rtl/jpc_rst_sync.sv
module jpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_chain
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/jpc_shift_stage.sv
module jpc_shift_stage
  import jpc_pkg::*;
#(
  parameter int W = 15
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         sel,
  input  tap_step_t    step,
  input  logic         tdi,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  output logic         tdo,
  output logic         tdo_en
);

  logic [W-1:0] sr_q, sr_d;
  logic         cap_en, sh_en, sr_en;
  logic         out_q, out_d;
  logic         oe_q, oe_d;

  // next state of the parallel-load / serial shift stage
  always_comb begin
    cap_en = sel & step.capture;
    sh_en  = sel & step.shift;
    sr_en  = cap_en | sh_en;
    sr_d   = sr_q;
    if (cap_en)     sr_d = par_in;
    else if (sh_en) sr_d = {tdi, sr_q[W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  // falling-edge output stage
  always_comb begin
    out_d = sr_q[0];
    oe_d  = sh_en;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign par_out = sr_q;
  assign tdo     = oe_q & out_q;
  assign tdo_en  = oe_q;

endmodule

// File: rtl/jpc_cmd_shadow.sv
module jpc_cmd_shadow #(
  parameter int W = 15
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         valid
);

  logic [W-1:0] hold_q, hold_d;
  logic         vld_q, vld_d;

  always_comb begin
    hold_d = d;
    vld_d  = load;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= hold_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign q     = hold_q;
  assign valid = vld_q;

endmodule

// File: rtl/jpc_exec_gen.sv
module jpc_exec_gen (
  input  logic tck,
  input  logic rst_n,
  input  logic sel,
  input  logic idle,
  output logic strobe
);

  logic live, live_q;
  logic fire_d, fire_q;

  always_comb begin
    live   = sel & idle;
    fire_d = live & ~live_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      live_q <= live;
      fire_q <= fire_d;
    end
  end

  assign strobe = fire_q;

endmodule

// File: rtl/jtag_pgm_cmd_reg.sv
module jtag_pgm_cmd_reg
  import jpc_pkg::*;
#(
  parameter int          CMD_W       = 15,
  parameter int          IR_W        = 4,
  parameter logic [3:0]  SEL_CODE    = 4'h5,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             tap_capture_dr,
  input  logic             tap_shift_dr,
  input  logic             tap_update_dr,
  input  logic             tap_run_idle,
  input  logic             tdi,
  input  logic [CMD_W-1:0] result_i,
  output logic             tdo,
  output logic             tdo_en,
  output logic [CMD_W-1:0] cmd_q,
  output logic             cmd_valid,
  output logic             exec_strobe
);

  localparam logic [IR_W-1:0] SEL_MATCH = IR_W'(SEL_CODE);

  logic             rst_n;
  logic             sel;
  tap_step_t        step;
  logic [CMD_W-1:0] stage_val;

  always_comb begin
    sel          = (ir_code == SEL_MATCH);
    step.capture = tap_capture_dr;
    step.shift   = tap_shift_dr;
    step.update  = tap_update_dr;
    step.idle    = tap_run_idle;
  end

  jpc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_n)
  );

  jpc_shift_stage #(.W(CMD_W)) u_stage (
    .tck     (tck),
    .rst_n   (rst_n),
    .sel     (sel),
    .step    (step),
    .tdi     (tdi),
    .par_in  (result_i),
    .par_out (stage_val),
    .tdo     (tdo),
    .tdo_en  (tdo_en)
  );

  jpc_cmd_shadow #(.W(CMD_W)) u_shadow (
    .tck   (tck),
    .rst_n (rst_n),
    .load  (sel & step.update),
    .d     (stage_val),
    .q     (cmd_q),
    .valid (cmd_valid)
  );

  jpc_exec_gen u_exec (
    .tck    (tck),
    .rst_n  (rst_n),
    .sel    (sel),
    .idle   (step.idle),
    .strobe (exec_strobe)
  );

endmodule

// File: rtl/jpc_cmd_reg_checker.sv
module jpc_cmd_reg_checker #(
  parameter int         CMD_W    = 15,
  parameter int         IR_W     = 4,
  parameter logic [3:0] SEL_CODE = 4'h5
) (
  input logic             tck,
  input logic             trst_n,
  input logic [IR_W-1:0]  ir_code,
  input logic             tap_shift_dr,
  input logic             tap_update_dr,
  input logic             tap_run_idle,
  input logic             tdo,
  input logic             tdo_en,
  input logic [CMD_W-1:0] cmd_q,
  input logic             cmd_valid,
  input logic             exec_strobe
);

  logic chosen;
  assign chosen = (ir_code == IR_W'(SEL_CODE));

  a_r5_cmd_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !$past(chosen && tap_update_dr) |-> $stable(cmd_q));

  a_r6_valid_after_update: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_valid |-> $past(chosen && tap_update_dr));

  a_r2_valid_needs_code: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_valid |-> ($past(ir_code) == IR_W'(SEL_CODE)));

  a_r7_exec_single: assert property (@(posedge tck) disable iff (!trst_n)
    exec_strobe |=> !exec_strobe);

  a_r7_exec_from_idle: assert property (@(posedge tck) disable iff (!trst_n)
    exec_strobe |-> $past(chosen && tap_run_idle));

  a_r8_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

  a_r8_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (chosen && tap_shift_dr));

  a_r10_exec_cmd_settled: assert property (@(posedge tck) disable iff (!trst_n)
    exec_strobe |-> $stable(cmd_q));

endmodule

bind jtag_pgm_cmd_reg jpc_cmd_reg_checker #(
  .CMD_W(CMD_W), .IR_W(IR_W), .SEL_CODE(SEL_CODE)
) u_chk (
  .tck           (tck),
  .trst_n        (trst_n),
  .ir_code       (ir_code),
  .tap_shift_dr  (tap_shift_dr),
  .tap_update_dr (tap_update_dr),
  .tap_run_idle  (tap_run_idle),
  .tdo           (tdo),
  .tdo_en        (tdo_en),
  .cmd_q         (cmd_q),
  .cmd_valid     (cmd_valid),
  .exec_strobe   (exec_strobe)
);

// File: tb/sim_jtag_pgm_cmd_reg.sv
module sim_jtag_pgm_cmd_reg;

  logic        clk;
  logic        trst_n;
  logic [3:0]  ir;
  logic        cap, sh, upd, idle;
  logic        tdi;
  logic [14:0] result_i;
  logic        tdo, tdo_en;
  logic [14:0] cmd_q;
  logic        cmd_valid, exec_strobe;

  jtag_pgm_cmd_reg u0 (
    .tck(clk), .trst_n(trst_n), .ir_code(ir),
    .tap_capture_dr(cap), .tap_shift_dr(sh), .tap_update_dr(upd), .tap_run_idle(idle),
    .tdi(tdi), .result_i(result_i), .tdo(tdo), .tdo_en(tdo_en),
    .cmd_q(cmd_q), .cmd_valid(cmd_valid), .exec_strobe(exec_strobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  int exec_cnt = 0, valid_cnt = 0;
  logic [14:0] cmd_at_exec = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] engine(input logic [14:0] c);
    return {c[7:0], c[14:8]} ^ 15'h01C3;
  endfunction

  // behavioural reference model
  bit ms1 = 0, ms2 = 0;
  bit mq[$];
  logic [14:0] mcmd = '0;
  bit mval = 0, mexe = 0, mprev = 0, men = 0, mtdo = 0;

  function automatic logic [14:0] q2v();
    logic [14:0] v;
    for (int k = 0; k < 15; k++) v[k] = mq[k];
    return v;
  endfunction

  initial for (int k = 0; k < 15; k++) mq.push_back(1'b0);

  always @(posedge clk) begin
    bit act, s;
    act = ms2;
    if (!trst_n) begin ms1 = 0; ms2 = 0; act = 0; end
    else begin ms2 = ms1; ms1 = 1; end
    if (!act) begin
      mq.delete();
      for (int k = 0; k < 15; k++) mq.push_back(1'b0);
      mcmd = '0; mval = 0; mexe = 0; mprev = 0;
    end else begin
      s = (ir == 4'h5);
      mexe  = s && idle && !mprev;
      mprev = s && idle;
      mval  = s && upd;
      if (s && upd) mcmd = q2v();
      if (s && cap) begin
        mq.delete();
        for (int k = 0; k < 15; k++) mq.push_back(result_i[k]);
      end else if (s && sh) begin
        void'(mq.pop_front());
        mq.push_back(tdi);
      end
    end
  end

  always @(negedge clk) begin
    if (!ms2 || !trst_n) begin men = 0; mtdo = 0; end
    else begin
      men  = (ir == 4'h5) && sh;
      mtdo = men ? mq[0] : 1'b0;
    end
  end

  // compare just before each rising edge; emulate the engine
  always @(negedge clk) begin
    #4;
    if (cmp_on) begin
      chk("R5 cmd_q", int'(cmd_q), int'(mcmd));
      chk("R6 cmd_valid", int'(cmd_valid), int'(mval));
      chk("R7 exec_strobe", int'(exec_strobe), int'(mexe));
      chk("R8 tdo_en", int'(tdo_en), int'(men));
      chk("R3 tdo", int'(tdo), int'(mtdo));
    end
    if (cmd_valid) valid_cnt++;
    if (exec_strobe) begin
      exec_cnt++;
      cmd_at_exec = cmd_q;
      result_i = engine(cmd_q);
    end
  end

  task automatic scan(input logic [14:0] c, input logic [3:0] code, input bit do_cap,
                      input int idle_n, output logic [14:0] seen);
    @(posedge clk); #1;
    ir = code;
    cap = do_cap;
    if (!do_cap) begin
      sh = 1'b1; tdi = c[0]; #8 seen[0] = tdo;
    end
    for (int i = (do_cap ? 0 : 1); i < 15; i++) begin
      @(posedge clk); #1;
      cap = 1'b0; sh = 1'b1; tdi = c[i];
      #8 seen[i] = tdo;
    end
    @(posedge clk); #1 sh = 1'b0;
    @(posedge clk); #1 upd = 1'b1;
    @(posedge clk); #1 upd = 1'b0;
    if (idle_n > 0) begin
      idle = 1'b1;
      repeat (idle_n) @(posedge clk);
      #1 idle = 1'b0;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [14:0] seen;
    int e0, v0;
    trst_n = 1'b1; ir = 4'h0; cap = 0; sh = 0; upd = 0; idle = 0; tdi = 0;
    result_i = 15'h2B6D;
    #2 trst_n = 1'b0;
    cmp_on = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cmd_q", int'(cmd_q), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 exec_strobe", int'(exec_strobe), 0);
    chk("R1 tdo_en", int'(tdo_en), 0);
    chk("R1 tdo", int'(tdo), 0);
    #2 trst_n = 1'b1;
    repeat (4) @(posedge clk);

    // first command, straight into a short idle stay
    scan(15'h1234, 4'h5, 1, 4, seen);
    chk("R3 capture of power-on result", int'(seen), 'h2B6D);
    chk("R5 cmd_q after update", int'(cmd_q), 'h1234);
    chk("R7 one strobe", exec_cnt, 1);
    chk("R10 cmd seen at strobe", int'(cmd_at_exec), 'h1234);

    // second command, no idle: nothing executes
    scan(15'h5A0F, 4'h5, 1, 0, seen);
    chk("R3 result of first command", int'(seen), int'(engine(15'h1234)));
    chk("R7 no strobe without idle", exec_cnt, 1);

    // third command, long idle stay
    scan(15'h6C31, 4'h5, 1, 30, seen);
    chk("R3 result unchanged without execute", int'(seen), int'(engine(15'h1234)));
    chk("R7 single strobe over long idle", exec_cnt, 2);
    chk("R6 one valid pulse per update", valid_cnt, 3);
    chk("R10 cmd seen at strobe", int'(cmd_at_exec), 'h6C31);

    // other instruction codes
    e0 = exec_cnt; v0 = valid_cnt;
    scan(15'h7FFF, 4'h4, 1, 5, seen);
    chk("R2 tdo quiet with code 4", int'(seen), 0);
    chk("R2 cmd_q held with code 4", int'(cmd_q), 'h6C31);
    scan(15'h0000, 4'hD, 1, 5, seen);
    chk("R2 tdo quiet with code D", int'(seen), 0);
    chk("R2 cmd_q held with code D", int'(cmd_q), 'h6C31);
    chk("R2 no strobe when deselected", exec_cnt, e0);
    chk("R2 no valid when deselected", valid_cnt, v0);

    // shift without capture returns the retained contents
    scan(15'h0001, 4'h5, 0, 2, seen);
    chk("R9 retained contents", int'(seen), 'h6C31);
    chk("R10 cmd seen at strobe", int'(cmd_at_exec), 'h0001);

    scan(15'h4000, 4'h5, 0, 0, seen);
    chk("R4 first tdi bit lands at bit 0", int'(seen), 'h0001);
    chk("R4 last tdi bit lands at bit 14", int'(cmd_q), 'h4000);

    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule